// File: doc/BRIEF.md
# Instruction Cache Line Refill Buffer

This block sits between an instruction cache and a 64-bit read bus and handles the refill of one line after a cache miss. When a miss is reported while the block is idle, it captures the 30-bit word address of the missed instruction. Two cycles later it raises a fetch request on the bus carrying that address. After the bus accepts the address, the bus returns the line as four doublewords, each holding two instructions. The doubleword that holds the missed instruction comes first. The rest follow upward in address and wrap to the bottom of the same 32-byte line.

Each returned doubleword is staged for one cycle and then stored in a line-wide fill buffer. In that staging cycle it is also forwarded to the fetch unit, tagged with its word address, so execution can resume before the line is complete. The bus may leave any number of idle cycles between beats.

Once all four doublewords are held, the block presents the complete line to the cache array for a fixed three-cycle write sequence. It then returns to idle. While a request is still waiting for its address acknowledge, the fetch unit can cancel it. The block then signals an abort to the bus and withdraws the request.

Top module: `icache_refill`

## Requirements
- R1: A miss presented while idle raises `bus_req` exactly two clock edges later, with `bus_addr` equal to the captured miss word address. `bus_addr` stays unchanged while the request is held.
- R2: `bus_req` stays high until `bus_addr_ack` is sampled high and is low in the cycle after the acknowledge.
- R3: Each read-data beat acknowledged in cycle k appears on `byp_data` in cycle k+1, with `byp_valid` high for that single cycle.
- R4: Beat i of a fill carries doubleword index (c + i) mod 4, where c is `miss_addr[2:1]`. `byp_addr` equals `{miss_addr[29:3], index, 1'b0}`.
- R5: Any number of idle cycles may fall between beats. The block waits without forwarding anything during them.
- R6: The cache write begins two cycles after the fourth beat's acknowledge. `cache_wr_en` stays high for exactly three consecutive cycles with `cache_wr_phase` 0, 1, 2. `cache_wr_line` equals `miss_addr[29:3]`, and doubleword j sits at `cache_wr_data[64*j+63:64*j]`.
- R7: `miss_valid` is ignored unless the block is idle, that is, during the request, fill and cache-write phases. `bus_addr` is unchanged and no second request follows.
- R8: `fetch_cancel` while `bus_req` is high and `bus_addr_ack` is low drives `bus_abort` high in that cycle, and `bus_req` is low in the next cycle. `fetch_cancel` in the cycle between miss and request prevents the request entirely. In both cases the block is idle afterwards.
- R9: Once the address is acknowledged, including when the acknowledge and `fetch_cancel` arrive in the same cycle, `fetch_cancel` has no effect. `bus_abort` stays low and the fill completes.
- R10: `bus_rd_ack` outside the fill phase is ignored and produces no `byp_valid`.
- R11: During and right after reset, `bus_req`, `bus_abort`, `byp_valid` and `cache_wr_en` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| miss_valid | input | 1 | Cache miss reported this cycle |
| miss_addr | input | 30 | Word address of the missed instruction |
| fetch_cancel | input | 1 | Fetch unit withdraws the pending miss |
| bus_req | output | 1 | Line fetch request |
| bus_addr | output | 30 | Word address of the request |
| bus_addr_ack | input | 1 | Bus accepted the request address |
| bus_abort | output | 1 | Withdraws the request presented this cycle |
| bus_rd_ack | input | 1 | Read-data beat valid on `bus_rd_data` |
| bus_rd_data | input | 64 | Read-data doubleword |
| byp_valid | output | 1 | Forwarded instruction pair is valid |
| byp_addr | output | 30 | Word address of the even instruction of the pair |
| byp_data | output | 64 | Forwarded doubleword |
| cache_wr_en | output | 1 | Line write to cache array active |
| cache_wr_phase | output | 2 | Step of the three-cycle write sequence |
| cache_wr_line | output | 27 | Line address being written |
| cache_wr_data | output | 256 | Whole line, doubleword j at bits 64j+63:64j |

## Verification
The bench targets each critical-doubleword position, including the last doubleword of the line, where a design that ignored the wrap would walk past the line end instead of returning to index 0. It varies the address-acknowledge delay and the idle gaps between beats. A design that counted cycles instead of acknowledges would then forward beats or start the write at the wrong time. It also times cancels in the gap cycle, in the request, and in the same cycle as the acknowledge; a wrong priority would abort an accepted fetch or leave a withdrawn one asserted. Finally, it sends stray data acknowledges and misses outside the fill. A design that did not qualify them would forward phantom beats or change the address in the middle of a line.

// File: rtl/icache_refill.sv
module icache_refill #(
  parameter  int ADDR_W   = 30,
  parameter  int DW       = 64,
  parameter  int LINE_DW  = 4,
  parameter  int COPY_CYC = 3,
  localparam int IDX_W    = $clog2(LINE_DW),
  localparam int LINE_W   = ADDR_W - IDX_W - 1,
  localparam int PH_W     = (COPY_CYC > 1) ? $clog2(COPY_CYC) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  miss_valid,
  input  logic [ADDR_W-1:0]     miss_addr,
  input  logic                  fetch_cancel,
  output logic                  bus_req,
  output logic [ADDR_W-1:0]     bus_addr,
  input  logic                  bus_addr_ack,
  output logic                  bus_abort,
  input  logic                  bus_rd_ack,
  input  logic [DW-1:0]         bus_rd_data,
  output logic                  byp_valid,
  output logic [ADDR_W-1:0]     byp_addr,
  output logic [DW-1:0]         byp_data,
  output logic                  cache_wr_en,
  output logic [PH_W-1:0]       cache_wr_phase,
  output logic [LINE_W-1:0]     cache_wr_line,
  output logic [LINE_DW*DW-1:0] cache_wr_data
);

  typedef enum logic [2:0] {S_IDLE, S_GAP, S_REQ, S_FILL, S_DRAIN, S_COPY} state_t;

  state_t            st;
  logic [ADDR_W-1:0] addr_q;
  logic [IDX_W-1:0]  cnt;
  logic              stg_v;
  logic [IDX_W-1:0]  stg_idx;
  logic [DW-1:0]     stg_data;
  logic [PH_W-1:0]   ph;
  logic [DW-1:0]     lbuf [LINE_DW];

  wire [IDX_W-1:0]  crit   = addr_q[IDX_W:1];
  wire [LINE_W-1:0] line_a = addr_q[ADDR_W-1:IDX_W+1];
  wire              beat   = (st == S_FILL) && bus_rd_ack;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      addr_q   <= '0;
      cnt      <= '0;
      stg_v    <= 1'b0;
      stg_idx  <= '0;
      stg_data <= '0;
      ph       <= '0;
    end else begin
      stg_v <= beat;
      if (beat) begin
        stg_data <= bus_rd_data;
        stg_idx  <= crit + cnt;
        cnt      <= cnt + 1'b1;
      end
      case (st)
        S_IDLE: begin
          cnt <= '0;
          if (miss_valid) begin
            addr_q <= miss_addr;
            st     <= S_GAP;
          end
        end
        S_GAP:   st <= fetch_cancel ? S_IDLE : S_REQ;
        S_REQ: begin
          if (bus_addr_ack)      st <= S_FILL;
          else if (fetch_cancel) st <= S_IDLE;
        end
        S_FILL:  if (bus_rd_ack && cnt == IDX_W'(LINE_DW - 1)) st <= S_DRAIN;
        S_DRAIN: begin
          ph <= '0;
          st <= S_COPY;
        end
        S_COPY: begin
          if (ph == PH_W'(COPY_CYC - 1)) st <= S_IDLE;
          else                           ph <= ph + 1'b1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk)
    if (stg_v) lbuf[stg_idx] <= stg_data;

  assign bus_req        = (st == S_REQ);
  assign bus_addr       = addr_q;
  assign bus_abort      = (st == S_REQ) && fetch_cancel && !bus_addr_ack;
  assign byp_valid      = stg_v;
  assign byp_addr       = {line_a, stg_idx, 1'b0};
  assign byp_data       = stg_data;
  assign cache_wr_en    = (st == S_COPY);
  assign cache_wr_phase = ph;
  assign cache_wr_line  = line_a;

  for (genvar j = 0; j < LINE_DW; j++) begin : g_line
    assign cache_wr_data[j*DW +: DW] = lbuf[j];
  end

endmodule

// File: rtl/icache_refill_chk.sv
module icache_refill_chk #(
  parameter  int ADDR_W   = 30,
  parameter  int COPY_CYC = 3,
  localparam int PH_W     = (COPY_CYC > 1) ? $clog2(COPY_CYC) : 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              miss_valid,
  input logic              bus_req,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_addr_ack,
  input logic              bus_abort,
  input logic              bus_rd_ack,
  input logic              byp_valid,
  input logic              cache_wr_en,
  input logic [PH_W-1:0]   cache_wr_phase
);

  // R1
  req_after_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_req) |-> $past(miss_valid, 2));

  // R1
  req_addr_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req |=> $stable(bus_addr));

  // R2
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && !bus_addr_ack && !bus_abort |=> bus_req);

  // R2
  req_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && bus_addr_ack |=> !bus_req);

  // R8
  abort_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_abort |-> bus_req && !bus_addr_ack);

  // R8
  abort_drops_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_abort |=> !bus_req);

  // R3
  byp_after_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    byp_valid |-> $past(bus_rd_ack));

  // R6
  copy_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cache_wr_en) |-> $past(cache_wr_phase) == PH_W'(COPY_CYC - 1));

  // R6
  copy_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cache_wr_en && $past(cache_wr_en) |-> cache_wr_phase == $past(cache_wr_phase) + PH_W'(1));

  // R7
  copy_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cache_wr_en |-> !bus_req && !byp_valid);

endmodule

bind icache_refill icache_refill_chk #(.ADDR_W(ADDR_W), .COPY_CYC(COPY_CYC)) chk_i (
  .clk(clk), .rst_n(rst_n), .miss_valid(miss_valid), .bus_req(bus_req),
  .bus_addr(bus_addr), .bus_addr_ack(bus_addr_ack), .bus_abort(bus_abort),
  .bus_rd_ack(bus_rd_ack), .byp_valid(byp_valid), .cache_wr_en(cache_wr_en),
  .cache_wr_phase(cache_wr_phase)
);

// File: tb/icache_refill_test.sv
module icache_refill_test;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         miss_valid, fetch_cancel, bus_addr_ack, bus_rd_ack;
  logic [29:0]  miss_addr;
  logic [63:0]  bus_rd_data;
  logic         bus_req, bus_abort, byp_valid, cache_wr_en;
  logic [29:0]  bus_addr, byp_addr;
  logic [63:0]  byp_data;
  logic [1:0]   cache_wr_phase;
  logic [26:0]  cache_wr_line;
  logic [255:0] cache_wr_data;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  icache_refill uut (
    .clk(clk), .rst_n(rst_n), .miss_valid(miss_valid), .miss_addr(miss_addr),
    .fetch_cancel(fetch_cancel), .bus_req(bus_req), .bus_addr(bus_addr),
    .bus_addr_ack(bus_addr_ack), .bus_abort(bus_abort), .bus_rd_ack(bus_rd_ack),
    .bus_rd_data(bus_rd_data), .byp_valid(byp_valid), .byp_addr(byp_addr),
    .byp_data(byp_data), .cache_wr_en(cache_wr_en), .cache_wr_phase(cache_wr_phase),
    .cache_wr_line(cache_wr_line), .cache_wr_data(cache_wr_data)
  );

  localparam int NV = 6;
  localparam logic [29:0] T_ADDR [NV] = '{30'h0000_1230, 30'h0ABC_DE43, 30'h1555_5554,
                                          30'h3FFF_FFF7, 30'h0000_0002, 30'h2468_ACE9};
  localparam int T_ACKD [NV] = '{0, 1, 3, 0, 2, 0};
  localparam int T_GAP  [NV] = '{0, 2, 1, 4, 0, 3};

  task automatic check(input string tag, input logic [255:0] act, input logic [255:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] beat_data(input logic [29:0] a, input int i);
    return {2'(i), a, 2'(i + 1), ~a};
  endfunction

  task automatic run_fill(input logic [29:0] a, input int ackd, input int gap,
                          input bit junk_miss, input bit stray_rd,
                          input bit cancel_at_ack, input bit cancel_in_fill);
    logic [63:0] expl [4];
    logic [1:0]  idx;
    miss_valid = 1'b1; miss_addr = a;
    @(negedge clk);
    miss_valid = 1'b0;
    check("R1 no request after one edge", 256'(bus_req), 256'(0));
    @(negedge clk);
    check("R1 request after two edges", 256'(bus_req), 256'(1));
    check("R1 request address", 256'(bus_addr), 256'(a));
    if (stray_rd) begin
      bus_rd_ack = 1'b1; bus_rd_data = 64'hDEAD_BEEF_0BAD_F00D;
      @(negedge clk);
      bus_rd_ack = 1'b0;
      check("R10 stray data ack in request", 256'(byp_valid), 256'(0));
      check("R2 request held", 256'(bus_req), 256'(1));
    end
    for (int d = 0; d < ackd; d++) begin
      @(negedge clk);
      check("R2 request held waiting ack", 256'(bus_req), 256'(1));
      check("R1 address stable", 256'(bus_addr), 256'(a));
    end
    bus_addr_ack = 1'b1;
    if (cancel_at_ack) begin
      fetch_cancel = 1'b1;
      #1 check("R9 no abort with ack", 256'(bus_abort), 256'(0));
    end
    @(negedge clk);
    bus_addr_ack = 1'b0;
    fetch_cancel = 1'b0;
    check("R2 request dropped after ack", 256'(bus_req), 256'(0));
    if (junk_miss) begin miss_valid = 1'b1; miss_addr = ~a; end
    if (cancel_in_fill) fetch_cancel = 1'b1;
    for (int i = 0; i < 4; i++) begin
      idx = 2'(a[2:1] + 2'(i));
      expl[idx] = beat_data(a, i);
      bus_rd_ack = 1'b1; bus_rd_data = beat_data(a, i);
      @(negedge clk);
      bus_rd_ack = 1'b0; bus_rd_data = '0;
      check("R3 bypass valid", 256'(byp_valid), 256'(1));
      check("R3 bypass data", 256'(byp_data), 256'(beat_data(a, i)));
      check("R4 bypass wrap address", 256'(byp_addr), 256'({a[29:3], idx, 1'b0}));
      check("R9 no abort in fill", 256'(bus_abort), 256'(0));
      check("R7 no request in fill", 256'(bus_req), 256'(0));
      if (i < 3)
        for (int g = 0; g < gap; g++) begin
          @(negedge clk);
          check("R5 no bypass in gap", 256'(byp_valid), 256'(0));
        end
    end
    check("R6 no write before full", 256'(cache_wr_en), 256'(0));
    for (int p = 0; p < 3; p++) begin
      @(negedge clk);
      check("R6 write enable", 256'(cache_wr_en), 256'(1));
      check("R6 write phase", 256'(cache_wr_phase), 256'(p));
      check("R6 write line", 256'(cache_wr_line), 256'(a[29:3]));
      check("R6 write data", cache_wr_data, {expl[3], expl[2], expl[1], expl[0]});
      check("R7 address kept", 256'(bus_addr), 256'(a));
      if (p == 2) begin miss_valid = 1'b0; fetch_cancel = 1'b0; end
    end
    @(negedge clk);
    check("R6 write ends after three", 256'(cache_wr_en), 256'(0));
    if (junk_miss)
      for (int q = 0; q < 3; q++) begin
        @(negedge clk);
        check("R7 ignored miss gives no request", 256'(bus_req), 256'(0));
      end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; miss_valid = 0; miss_addr = '0; fetch_cancel = 0;
    bus_addr_ack = 0; bus_rd_ack = 0; bus_rd_data = '0;
    repeat (3) @(negedge clk);
    check("R11 reset request", 256'(bus_req), 256'(0));
    check("R11 reset abort", 256'(bus_abort), 256'(0));
    check("R11 reset bypass", 256'(byp_valid), 256'(0));
    check("R11 reset write", 256'(cache_wr_en), 256'(0));
    rst_n = 1'b1;
    @(negedge clk);
    check("R11 idle after reset", 256'(bus_req), 256'(0));

    for (int v = 0; v < NV; v++)
      run_fill(T_ADDR[v], T_ACKD[v], T_GAP[v], 1'b0, 1'b0, 1'b0, 1'b0);

    // R8: cancel while request pending
    miss_valid = 1'b1; miss_addr = 30'h0123_4566;
    @(negedge clk); miss_valid = 1'b0;
    @(negedge clk);
    check("R8 request up", 256'(bus_req), 256'(1));
    fetch_cancel = 1'b1;
    #1 check("R8 abort with cancel", 256'(bus_abort), 256'(1));
    @(negedge clk); fetch_cancel = 1'b0;
    check("R8 request withdrawn", 256'(bus_req), 256'(0));
    check("R8 abort single cycle", 256'(bus_abort), 256'(0));
    // R10: data ack while idle
    bus_rd_ack = 1'b1;
    @(negedge clk); bus_rd_ack = 1'b0;
    check("R10 stray data ack idle", 256'(byp_valid), 256'(0));

    // R8: cancel in the cycle between miss and request
    miss_valid = 1'b1; miss_addr = 30'h0000_0F00;
    @(negedge clk); miss_valid = 1'b0; fetch_cancel = 1'b1;
    @(negedge clk); fetch_cancel = 1'b0;
    check("R8 no request after early cancel", 256'(bus_req), 256'(0));
    @(negedge clk);
    check("R8 still no request", 256'(bus_req), 256'(0));

    // R7 junk miss, R10 stray data ack, R9 cancel with ack and during fill
    run_fill(30'h1234_5675, 1, 1, 1'b1, 1'b1, 1'b1, 1'b1);
    run_fill(30'h0765_4323, 0, 0, 1'b1, 1'b0, 1'b0, 1'b1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule